// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a 32-bit in-order processor core with five stages: fetch, decode, execute, memory and write-back. It runs a small integer instruction subset: word load and store, register-register add, subtract, AND, OR and signed set-less-than, add-immediate, AND-immediate, branch-if-equal, branch-if-not-equal and an unconditional jump. The instruction store is a word-indexed array read combinationally. The data store is a word-indexed array written on the clock edge. Both are held inside the block and are preloaded from outside before reset is released.

Results move between stages over operand bypass paths, so dependent instructions issue back to back. Stalls are inserted only where a value cannot arrive in time: a use right after a load, or a branch whose operands are still being produced. Branches resolve in decode. Fetch assumes not-taken and discards the one wrong-path instruction when a branch is taken or a jump is decoded. The only outputs are debug views of the fetch address and of the register-file write port.

Top module: `pipe_core`

## Requirements
- R1: While reset is asserted, the fetch address reads 0 and the write port shows no write. After reset, fetch starts at address 0.
- R2: Register-register instructions (opcode 0) with function codes 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR and 0x2A signed set-less-than write their result to register rd.
- R3: Add-immediate (opcode 0x08) sign-extends its 16-bit immediate. AND-immediate (opcode 0x0C) zero-extends it. Both write register rt.
- R4: A dependent instruction in execute takes its operand from the newest older producer. The instruction one ahead takes priority over the instruction two ahead, and both take priority over the register file.
- R5: Register 0 always reads as zero. Writes aimed at it produce no write-port activity and never feed a bypass.
- R6: When a load (opcode 0x23) is followed directly by an instruction that reads its destination, the pipeline stalls for exactly one cycle and the consumer sees the loaded value.
- R7: A store (opcode 0x2B) writes rt to the data word at rs plus the sign-extended offset. A later load from that address returns the stored value.
- R8: A taken branch-if-equal (opcode 0x04) or branch-if-not-equal (opcode 0x05) continues at PC+4 plus the offset times 4. The instruction fetched after the branch is discarded.
- R9: A branch that is not taken falls through with no instruction discarded.
- R10: A branch whose operand is being produced by the instruction in execute, or by a load in the memory stage, stalls until the value can be compared. It then resolves on the correct value.
- R11: A jump (opcode 0x02) continues at the upper four bits of PC+4 joined with its 26-bit word target, and discards the instruction fetched after it.
- R12: An unknown opcode, or a register-register instruction with an unlisted function code, changes no register.
- R13: A value written back in a cycle is seen by an instruction reading that register in decode during the same cycle.
- R14: With no stall and no redirect, the fetch address advances by 4 every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbg_pc | output | 32 | Current fetch address |
| dbg_wr_en | output | 1 | Register-file write of a nonzero register this cycle |
| dbg_wr_idx | output | 5 | Register being written |
| dbg_wr_data | output | 32 | Value being written |

## Verification
Four directed programs drive the core. The arithmetic program chains each result into the next instruction, one slot or two slots later, so that the EX-stage, MEM-stage and write-back bypass paths are each exercised. A pair of back-to-back writes to one register tells apart the correct bypass priority from the reversed one. The memory program separates a stalled load-use pair from a pair one slot apart by the cycle stamps of their write-backs. The branch and jump programs place marker instructions on the wrong path, so that a missing flush or a missed stall shows up as an extra or missing write. Unknown encodings sit between live instructions to show they change no register.

// File: rtl/pipe_core_pkg.sv
package pipe_core_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_JUMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_BNE   = 6'h05;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_ANDI  = 6'h0C;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111
    } alu_fn_e;

    typedef struct packed {
        logic       reg_write;
        logic       mem_read;
        logic       mem_write;
        logic       use_imm;
        logic       dst_is_rt;
        logic       br_eq;
        logic       br_ne;
        logic       jump;
        logic       zero_ext;
        logic [1:0] alu_class;
    } ctrl_t;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] pc4;
        logic [XLEN-1:0] instr;
    } fd_t;

    typedef struct packed {
        ctrl_t           ctrl;
        alu_fn_e         alu_fn;
        logic [XLEN-1:0] a_val;
        logic [XLEN-1:0] b_val;
        logic [XLEN-1:0] imm;
        logic [RIDX-1:0] src_a;
        logic [RIDX-1:0] src_b;
        logic [RIDX-1:0] dst;
    } dx_t;

    typedef struct packed {
        logic            reg_write;
        logic            mem_read;
        logic            mem_write;
        logic [XLEN-1:0] alu_y;
        logic [XLEN-1:0] st_data;
        logic [RIDX-1:0] dst;
    } xm_t;

    typedef struct packed {
        logic            reg_write;
        logic [XLEN-1:0] wdata;
        logic [RIDX-1:0] dst;
    } mw_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        fd_t             fd;
        dx_t             dx;
        xm_t             xm;
        mw_t             mw;
    } core_state_t;

endpackage

// File: rtl/pipe_core_decode.sv
module pipe_core_decode
    import pipe_core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl,
    output alu_fn_e    alu_fn
);

    always_comb begin
        ctrl = '0;
        unique case (opcode)
            OPC_RTYPE: begin
                if (funct == FN_ADD || funct == FN_SUB || funct == FN_AND ||
                    funct == FN_OR  || funct == FN_SLT) begin
                    ctrl.reg_write = 1'b1;
                    ctrl.alu_class = 2'b10;
                end
            end
            OPC_LOAD: begin
                ctrl.reg_write = 1'b1;
                ctrl.mem_read  = 1'b1;
                ctrl.use_imm   = 1'b1;
                ctrl.dst_is_rt = 1'b1;
            end
            OPC_STORE: begin
                ctrl.mem_write = 1'b1;
                ctrl.use_imm   = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.br_eq     = 1'b1;
                ctrl.alu_class = 2'b01;
            end
            OPC_BNE: begin
                ctrl.br_ne     = 1'b1;
                ctrl.alu_class = 2'b01;
            end
            OPC_ADDI: begin
                ctrl.reg_write = 1'b1;
                ctrl.use_imm   = 1'b1;
                ctrl.dst_is_rt = 1'b1;
            end
            OPC_ANDI: begin
                ctrl.reg_write = 1'b1;
                ctrl.use_imm   = 1'b1;
                ctrl.dst_is_rt = 1'b1;
                ctrl.zero_ext  = 1'b1;
                ctrl.alu_class = 2'b11;
            end
            OPC_JUMP: ctrl.jump = 1'b1;
            default: ctrl = '0;
        endcase
    end

    always_comb begin
        unique case (ctrl.alu_class)
            2'b00: alu_fn = ALU_ADD;
            2'b01: alu_fn = ALU_SUB;
            2'b11: alu_fn = ALU_AND;
            default: begin
                unique case (funct)
                    FN_SUB:  alu_fn = ALU_SUB;
                    FN_AND:  alu_fn = ALU_AND;
                    FN_OR:   alu_fn = ALU_OR;
                    FN_SLT:  alu_fn = ALU_SLT;
                    default: alu_fn = ALU_ADD;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/pipe_core_alu.sv
module pipe_core_alu
    import pipe_core_pkg::*;
(
    input  alu_fn_e         fn,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    always_comb begin
        unique case (fn)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/pipe_core_regfile.sv
module pipe_core_regfile
    import pipe_core_pkg::*;
#(
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RIDX-1:0] ra_idx,
    input  logic [RIDX-1:0] rb_idx,
    output logic [XLEN-1:0] ra_data,
    output logic [XLEN-1:0] rb_data,
    input  logic            we,
    input  logic [RIDX-1:0] w_idx,
    input  logic [XLEN-1:0] w_data
);

    logic [XLEN-1:0] regs_q [NREG];
    logic            wr_live;

    assign wr_live = we && (w_idx != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (wr_live) begin
            regs_q[w_idx] <= w_data;
        end
    end

    always_comb begin
        ra_data = (wr_live && w_idx == ra_idx) ? w_data : regs_q[ra_idx];
        rb_data = (wr_live && w_idx == rb_idx) ? w_data : regs_q[rb_idx];
    end

    // R5
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_idx == '0) |-> (ra_data == '0));

endmodule

// File: rtl/pipe_core_hazard.sv
module pipe_core_hazard
    import pipe_core_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RIDX-1:0] id_rs,
    input  logic [RIDX-1:0] id_rt,
    input  logic            id_branch,
    input  logic [RIDX-1:0] ex_rs,
    input  logic [RIDX-1:0] ex_rt,
    input  logic            ex_reg_write,
    input  logic            ex_mem_read,
    input  logic [RIDX-1:0] ex_dst,
    input  logic            mem_reg_write,
    input  logic            mem_mem_read,
    input  logic [RIDX-1:0] mem_dst,
    input  logic            wb_reg_write,
    input  logic [RIDX-1:0] wb_dst,
    output logic            stall,
    output logic [1:0]      fwd_a,
    output logic [1:0]      fwd_b,
    output logic            cmp_fwd_a,
    output logic            cmp_fwd_b
);

    logic ex_hits_id, mem_hits_id, load_use, br_wait;

    always_comb begin
        ex_hits_id  = (ex_dst != '0) && (ex_dst == id_rs || ex_dst == id_rt);
        mem_hits_id = (mem_dst != '0) && (mem_dst == id_rs || mem_dst == id_rt);
        load_use    = ex_mem_read && ex_hits_id;
        br_wait     = id_branch && ((ex_reg_write && ex_hits_id) ||
                                    (mem_mem_read && mem_hits_id));
        stall       = load_use || br_wait;

        if (mem_reg_write && mem_dst != '0 && mem_dst == ex_rs)     fwd_a = 2'b10;
        else if (wb_reg_write && wb_dst != '0 && wb_dst == ex_rs)   fwd_a = 2'b01;
        else                                                        fwd_a = 2'b00;

        if (mem_reg_write && mem_dst != '0 && mem_dst == ex_rt)     fwd_b = 2'b10;
        else if (wb_reg_write && wb_dst != '0 && wb_dst == ex_rt)   fwd_b = 2'b01;
        else                                                        fwd_b = 2'b00;

        cmp_fwd_a = mem_reg_write && mem_dst != '0 && mem_dst == id_rs;
        cmp_fwd_b = mem_reg_write && mem_dst != '0 && mem_dst == id_rt;
    end

    // R4
    fwd_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a == 2'b01) |-> !(mem_reg_write && mem_dst != '0 && mem_dst == ex_rs));

endmodule

// File: rtl/pipe_core.sv
module pipe_core
    import pipe_core_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] dbg_pc,
    output logic        dbg_wr_en,
    output logic [4:0]  dbg_wr_idx,
    output logic [31:0] dbg_wr_data
);

    localparam int IA = $clog2(IMEM_WORDS);
    localparam int DA = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
    end

    core_state_t st_d, st_q;

    logic [XLEN-1:0] id_instr, rf_a, rf_b, cmp_a, cmp_b, ex_opa, ex_opb, ex_alu_b, ex_y;
    logic [XLEN-1:0] id_sext, id_imm, mem_rdata;
    ctrl_t           id_ctrl;
    alu_fn_e         id_fn;
    logic            stall, cmp_fwd_a, cmp_fwd_b, take_br, redirect;
    logic [1:0]      fwd_a, fwd_b;

    assign id_instr = st_q.fd.valid ? st_q.fd.instr : '0;

    pipe_core_decode u_dec (
        .opcode (id_instr[31:26]),
        .funct  (id_instr[5:0]),
        .ctrl   (id_ctrl),
        .alu_fn (id_fn)
    );

    pipe_core_regfile #(.NREG(32)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (id_instr[25:21]),
        .rb_idx  (id_instr[20:16]),
        .ra_data (rf_a),
        .rb_data (rf_b),
        .we      (st_q.mw.reg_write),
        .w_idx   (st_q.mw.dst),
        .w_data  (st_q.mw.wdata)
    );

    pipe_core_hazard u_hz (
        .clk           (clk),
        .rst_n         (rst_n),
        .id_rs         (id_instr[25:21]),
        .id_rt         (id_instr[20:16]),
        .id_branch     (id_ctrl.br_eq | id_ctrl.br_ne),
        .ex_rs         (st_q.dx.src_a),
        .ex_rt         (st_q.dx.src_b),
        .ex_reg_write  (st_q.dx.ctrl.reg_write),
        .ex_mem_read   (st_q.dx.ctrl.mem_read),
        .ex_dst        (st_q.dx.dst),
        .mem_reg_write (st_q.xm.reg_write),
        .mem_mem_read  (st_q.xm.mem_read),
        .mem_dst       (st_q.xm.dst),
        .wb_reg_write  (st_q.mw.reg_write),
        .wb_dst        (st_q.mw.dst),
        .stall         (stall),
        .fwd_a         (fwd_a),
        .fwd_b         (fwd_b),
        .cmp_fwd_a     (cmp_fwd_a),
        .cmp_fwd_b     (cmp_fwd_b)
    );

    pipe_core_alu u_alu (
        .fn (st_q.dx.alu_fn),
        .a  (ex_opa),
        .b  (ex_alu_b),
        .y  (ex_y)
    );

    always_comb begin
        st_d = st_q;

        // decode-stage operands and branch resolution
        id_sext  = {{(XLEN-16){id_instr[15]}}, id_instr[15:0]};
        id_imm   = id_ctrl.zero_ext ? {{(XLEN-16){1'b0}}, id_instr[15:0]} : id_sext;
        cmp_a    = cmp_fwd_a ? st_q.xm.alu_y : rf_a;
        cmp_b    = cmp_fwd_b ? st_q.xm.alu_y : rf_b;
        take_br  = (id_ctrl.br_eq && cmp_a == cmp_b) || (id_ctrl.br_ne && cmp_a != cmp_b);
        redirect = !stall && (take_br || id_ctrl.jump);

        // fetch
        if (stall) begin
            st_d.pc = st_q.pc;
            st_d.fd = st_q.fd;
        end else if (redirect) begin
            st_d.pc = id_ctrl.jump ? {st_q.fd.pc4[31:28], id_instr[25:0], 2'b00}
                                   : st_q.fd.pc4 + {id_sext[XLEN-3:0], 2'b00};
            st_d.fd = '0;
        end else begin
            st_d.pc       = st_q.pc + 32'd4;
            st_d.fd.valid = 1'b1;
            st_d.fd.pc4   = st_q.pc + 32'd4;
            st_d.fd.instr = imem[st_q.pc[IA+1:2]];
        end

        // decode -> execute
        if (stall) begin
            st_d.dx = '0;
        end else begin
            st_d.dx.ctrl   = id_ctrl;
            st_d.dx.alu_fn = id_fn;
            st_d.dx.a_val  = rf_a;
            st_d.dx.b_val  = rf_b;
            st_d.dx.imm    = id_imm;
            st_d.dx.src_a  = id_instr[25:21];
            st_d.dx.src_b  = id_instr[20:16];
            st_d.dx.dst    = id_ctrl.dst_is_rt ? id_instr[20:16] : id_instr[15:11];
        end

        // execute
        unique case (fwd_a)
            2'b10:   ex_opa = st_q.xm.alu_y;
            2'b01:   ex_opa = st_q.mw.wdata;
            default: ex_opa = st_q.dx.a_val;
        endcase
        unique case (fwd_b)
            2'b10:   ex_opb = st_q.xm.alu_y;
            2'b01:   ex_opb = st_q.mw.wdata;
            default: ex_opb = st_q.dx.b_val;
        endcase
        ex_alu_b = st_q.dx.ctrl.use_imm ? st_q.dx.imm : ex_opb;

        st_d.xm.reg_write = st_q.dx.ctrl.reg_write;
        st_d.xm.mem_read  = st_q.dx.ctrl.mem_read;
        st_d.xm.mem_write = st_q.dx.ctrl.mem_write;
        st_d.xm.alu_y     = ex_y;
        st_d.xm.st_data   = ex_opb;
        st_d.xm.dst       = st_q.dx.dst;

        // memory
        mem_rdata         = st_q.xm.mem_read ? dmem[st_q.xm.alu_y[DA+1:2]] : '0;
        st_d.mw.reg_write = st_q.xm.reg_write;
        st_d.mw.wdata     = st_q.xm.mem_read ? mem_rdata : st_q.xm.alu_y;
        st_d.mw.dst       = st_q.xm.dst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst_n && st_q.xm.mem_write) dmem[st_q.xm.alu_y[DA+1:2]] <= st_q.xm.st_data;
    end

    assign dbg_pc      = st_q.pc;
    assign dbg_wr_en   = st_q.mw.reg_write && (st_q.mw.dst != '0);
    assign dbg_wr_idx  = st_q.mw.dst;
    assign dbg_wr_data = st_q.mw.wdata;

    // R6
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(st_q.pc) && $stable(st_q.fd));

    // R6
    bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (st_q.dx.ctrl == '0));

    // R8
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !st_q.fd.valid);

    // R14
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !redirect) |=> (st_q.pc == $past(st_q.pc) + 32'd4));

endmodule

// File: tb/sim_pipe_core.sv
module sim_pipe_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] dbg_pc;
    logic        dbg_wr_en;
    logic [4:0]  dbg_wr_idx;
    logic [31:0] dbg_wr_data;

    always #2.5 clk = ~clk;

    pipe_core u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .dbg_pc      (dbg_pc),
        .dbg_wr_en   (dbg_wr_en),
        .dbg_wr_idx  (dbg_wr_idx),
        .dbg_wr_data (dbg_wr_data)
    );

    int nchk = 0;
    int nerr = 0;

    logic [31:0] prog [64];
    int          plen;
    logic [4:0]  exp_idx [32];
    logic [31:0] exp_dat [32];
    string       exp_req [32];
    int          nexp;
    logic [4:0]  cap_idx [64];
    logic [31:0] cap_dat [64];
    int          cap_cyc [64];
    int          ncap;
    logic [31:0] pc_tr [64];
    int          ntr;
    int          cyc = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (ntr < 64) begin
                pc_tr[ntr] = dbg_pc;
                ntr = ntr + 1;
            end
            if (dbg_wr_en && ncap < 64) begin
                cap_idx[ncap] = dbg_wr_idx;
                cap_dat[ncap] = dbg_wr_data;
                cap_cyc[ncap] = cyc;
                ncap = ncap + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] rt_op(int rs, int rt, int rd, logic [5:0] fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] it_op(logic [5:0] op, int rs, int rt, int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    task automatic put(input logic [31:0] w);
        prog[plen] = w;
        plen++;
    endtask

    task automatic expect_wr(input int idx, input logic [31:0] d, input string req);
        exp_idx[nexp] = idx[4:0];
        exp_dat[nexp] = d;
        exp_req[nexp] = req;
        nexp++;
    endtask

    task automatic run_prog(input int ncyc);
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 64; i++) begin
            u0.imem[i] = (i < plen) ? prog[i] : 32'd0;
            u0.dmem[i] = 32'd0;
        end
        ncap = 0;
        ntr  = 0;
        @(negedge clk);
        // R1: reset state
        chk(dbg_pc == 32'd0, "R1", "pc in reset", dbg_pc, 32'd0);
        chk(dbg_wr_en == 1'b0, "R1", "write in reset", {31'd0, dbg_wr_en}, 32'd0);
        rst_n = 1'b1;
        repeat (ncyc) @(negedge clk);
    endtask

    task automatic cmp_writes(input string tag);
        chk(ncap == nexp, "R12", {tag, " write count"}, ncap, nexp);
        for (int i = 0; i < nexp; i++) begin
            if (i < ncap) begin
                chk(cap_idx[i] == exp_idx[i], exp_req[i], $sformatf("%s write %0d reg", tag, i),
                    {27'd0, cap_idx[i]}, {27'd0, exp_idx[i]});
                chk(cap_dat[i] == exp_dat[i], exp_req[i], $sformatf("%s write %0d data", tag, i),
                    cap_dat[i], exp_dat[i]);
            end
        end
    endtask

    task automatic test_alu;
        plen = 0; nexp = 0;
        put(it_op(6'h08, 0, 1, 5));                    expect_wr(1, 32'd5, "R3");
        put(it_op(6'h08, 0, 2, -3));                   expect_wr(2, 32'hFFFF_FFFD, "R3");
        put(rt_op(1, 2, 3, 6'h20));                    expect_wr(3, 32'd2, "R4");
        put(rt_op(1, 2, 4, 6'h22));                    expect_wr(4, 32'd8, "R2");
        put(rt_op(1, 2, 5, 6'h24));                    expect_wr(5, 32'd5, "R2");
        put(rt_op(1, 2, 6, 6'h25));                    expect_wr(6, 32'hFFFF_FFFD, "R2");
        put(rt_op(2, 1, 7, 6'h2A));                    expect_wr(7, 32'd1, "R2");
        put(rt_op(1, 2, 8, 6'h2A));                    expect_wr(8, 32'd0, "R2");
        put(it_op(6'h0C, 2, 9, 'hFFFF));               expect_wr(9, 32'h0000_FFFD, "R3");
        put(rt_op(3, 3, 10, 6'h20));                   expect_wr(10, 32'd4, "R4");
        put(it_op(6'h08, 0, 11, 1));                   expect_wr(11, 32'd1, "R4");
        put(it_op(6'h08, 0, 11, 2));                   expect_wr(11, 32'd2, "R4");
        put(rt_op(11, 0, 12, 6'h20));                  expect_wr(12, 32'd2, "R4");
        put(rt_op(1, 0, 13, 6'h20));                   expect_wr(13, 32'd5, "R2");
        put(it_op(6'h08, 0, 14, 7));                   expect_wr(14, 32'd7, "R13");
        put(32'd0);
        put(32'd0);
        put(rt_op(14, 0, 15, 6'h20));                  expect_wr(15, 32'd7, "R13");
        put(it_op(6'h08, 0, 0, 9));
        put(rt_op(0, 0, 16, 6'h20));                   expect_wr(16, 32'd0, "R5");
        run_prog(40);
        cmp_writes("alu");
    endtask

    task automatic test_mem;
        plen = 0; nexp = 0;
        put(it_op(6'h08, 0, 1, 'h55));                 expect_wr(1, 32'h55, "R3");
        put(it_op(6'h2B, 0, 1, 8));
        put(it_op(6'h23, 0, 2, 8));                    expect_wr(2, 32'h55, "R7");
        put(rt_op(2, 2, 3, 6'h20));                    expect_wr(3, 32'hAA, "R6");
        put(it_op(6'h23, 0, 4, 8));                    expect_wr(4, 32'h55, "R7");
        put(32'd0);
        put(rt_op(4, 1, 5, 6'h20));                    expect_wr(5, 32'hAA, "R4");
        run_prog(30);
        cmp_writes("mem");
        if (ncap >= 5) begin
            // R6: one stall cycle between load and dependent use
            chk(cap_cyc[2] - cap_cyc[1] == 2, "R6", "load-use spacing",
                cap_cyc[2] - cap_cyc[1], 32'd2);
            chk(cap_cyc[4] - cap_cyc[3] == 2, "R6", "load then gap spacing",
                cap_cyc[4] - cap_cyc[3], 32'd2);
        end
    endtask

    task automatic test_branch;
        plen = 0; nexp = 0;
        put(it_op(6'h08, 0, 1, 3));                    expect_wr(1, 32'd3, "R3");
        put(it_op(6'h08, 0, 2, 3));                    expect_wr(2, 32'd3, "R10");
        put(it_op(6'h04, 1, 2, 2));
        put(it_op(6'h08, 0, 3, 1));
        put(it_op(6'h08, 0, 4, 1));
        put(it_op(6'h05, 1, 2, 5));
        put(it_op(6'h08, 0, 5, 6));                    expect_wr(5, 32'd6, "R9");
        put(it_op(6'h05, 1, 0, 1));
        put(it_op(6'h08, 0, 6, 1));
        put(it_op(6'h08, 0, 7, 9));                    expect_wr(7, 32'd9, "R8");
        put(it_op(6'h23, 0, 8, 4));                    expect_wr(8, 32'd0, "R10");
        put(it_op(6'h04, 8, 0, 1));
        put(it_op(6'h08, 0, 9, 1));
        put(it_op(6'h08, 0, 10, 10));                  expect_wr(10, 32'd10, "R8");
        run_prog(40);
        cmp_writes("branch");
    endtask

    task automatic test_jump;
        bit seen8, seen12, step_ok;
        plen = 0; nexp = 0;
        put({6'h02, 26'd3});
        put(it_op(6'h08, 0, 1, 1));
        put(it_op(6'h08, 0, 2, 2));
        put(it_op(6'h08, 0, 3, 3));                    expect_wr(3, 32'd3, "R11");
        put({6'h3F, 5'd0, 5'd4, 16'd5});
        put(rt_op(3, 3, 5, 6'h27));
        put(it_op(6'h08, 3, 6, 1));                    expect_wr(6, 32'd4, "R12");
        run_prog(20);
        cmp_writes("jump");
        seen8 = 0; seen12 = 0; step_ok = 0;
        for (int i = 0; i < 8 && i < ntr; i++) begin
            if (pc_tr[i] == 32'd8) seen8 = 1;
            if (pc_tr[i] == 32'd12 && !seen12) begin
                seen12 = 1;
                if (i + 1 < ntr) step_ok = (pc_tr[i+1] == 32'd16);
            end
        end
        chk(!seen8, "R11", "skipped fetch address seen", {31'd0, seen8}, 32'd0);
        chk(seen12, "R11", "jump target reached", {31'd0, seen12}, 32'd1);
        chk(step_ok, "R14", "sequential step after target", {31'd0, step_ok}, 32'd1);
    endtask

    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        ncap = 0;
        ntr  = 0;
        test_alu();
        test_mem();
        test_branch();
        test_jump();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule